// File: doc/BRIEF.md
# Eight-bit event timer with power-of-two prescaler

This block is an 8-bit up-counter for a small microcontroller. The count source is either a one-cycle instruction tick from the core or an asynchronous external pin. When the pin is the source, it passes through a two-flop synchronizer and an edge detector. A control bit chooses whether rising or falling edges count. The qualified events then pass to an 8-bit prescaler. The prescaler either divides them by a power of two chosen through a 3-bit field, or is bypassed so that every event advances the counter.

Software reaches the block through a small synchronous register bus with a 2-bit address. Address 0 holds the counter, address 1 the control fields and address 2 the overflow flag. A write to the counter loads the new value and zeroes the prescaler. The counter then ignores events for two cycles, so a freshly loaded value is not disturbed at once. When the counter wraps, a sticky flag drives the interrupt output. The flag stays set until software writes zero to it.

Top module: `tick_timer8`

## Requirements
- R1: After reset the counter, the control fields and the overflow flag all read zero and `ovf_irq` is low. An access to address 3 reads zero.
- R2: With control bit 0 clear, the counter increments on each cycle in which `inst_tick` is high, and the pin is ignored.
- R3: With control bit 0 set, the pin is the source and `inst_tick` is ignored. A qualifying pin change that is set up before clock edge k is visible in the counter after edge k+2 and not earlier.
- R4: Control bit 1 chooses the counted pin edge: 0 counts rising edges, 1 counts falling edges. Edges of the other polarity do not count.
- R5: With control bit 2 clear, the counter advances once per 2^(s+1) source events, where s is control bits 5:3. Control bits 7:6 read zero.
- R6: With control bit 2 set, the prescaler is bypassed and every source event advances the counter by one.
- R7: An increment from 0xFF to 0x00 sets the overflow flag, which reads as bit 0 at address 2 and drives `ovf_irq`.
- R8: The flag stays set until a write to address 2 with data bit 0 equal to 0. A write with bit 0 equal to 1 leaves the flag unchanged.
- R9: A write to address 0 loads the written value and zeroes the prescaler. Source events in the two cycles after that write are discarded.
- R10: When an overflow and a flag-clearing write occur in the same cycle, the flag ends set.
- R11: When a counter write and a source event occur in the same cycle, the written value is loaded and the event is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| inst_tick | input | 1 | One-cycle instruction clock enable |
| ext_pin | input | 1 | Asynchronous external count input |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address (0 counter, 1 control, 2 flag) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| ovf_irq | output | 1 | Overflow interrupt flag |

## Verification
Two pairs of actions can land in the same cycle. An increment from 0xFF can meet a software clear of the flag, and a counter load can meet a live source event. The bench provokes both on purpose. It loads 0xFF, waits out the two-cycle guard window, and then drives a tick together with the flag write, or a tick together with a counter write, on one edge. It then reads the flag and the counter back over the bus. The expected results are that the flag stays set and that the loaded value replaces the count.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int TMR_W      = 8;
  localparam int PRE_W      = 8;
  localparam int SEL_W      = $clog2(PRE_W);
  localparam int SYNC_DEPTH = 2;
  localparam int GUARD_CYC  = 2;

  localparam logic [1:0] A_COUNT = 2'd0;
  localparam logic [1:0] A_CTRL  = 2'd1;
  localparam logic [1:0] A_FLAG  = 2'd2;

  typedef struct packed {
    logic [SEL_W-1:0] pre_sel;
    logic             bypass;
    logic             edge_fall;
    logic             src_ext;
  } tmr_ctrl_t;

  localparam int CTRL_W = $bits(tmr_ctrl_t);

  // Low bits of the prescaler that must all be ones for a divided tick.
  function automatic logic [PRE_W-1:0] tap_mask(input logic [SEL_W-1:0] sel);
    logic [PRE_W-1:0] ones;
    ones = '1;
    return ones >> (SEL_W'(PRE_W - 1) - sel);
  endfunction

  function automatic logic [TMR_W-1:0] bump(input logic [TMR_W-1:0] v);
    return v + TMR_W'(1);
  endfunction

endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int STAGES = tmr_pkg::SYNC_DEPTH
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);

  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], pin};
  end

  assign rise =  sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall = ~sh_q[STAGES-1] &  sh_q[STAGES];

  // R3: a detected edge cannot repeat on the following cycle
  a_r3_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
  a_r4_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);

endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_in,
  input  logic             clr,
  input  logic             bypass,
  input  logic [SEL_W-1:0] sel,
  output logic             step
);

  logic [PRE_W-1:0] pre_q;
  logic             tap_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pre_q <= '0;
    else if (clr)   pre_q <= '0;
    else if (ev_in) pre_q <= pre_q + PRE_W'(1);
  end

  assign tap_hit = &(pre_q | ~tap_mask(sel));
  assign step    = bypass ? ev_in : (ev_in & tap_hit);

  // R5: a divided tick only ever comes from a source event
  a_r5_step_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> ev_in);
  // R6: bypass passes every event through
  a_r6_bypass_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass && ev_in) |-> step);

endmodule

// File: rtl/tmr_count.sv
module tmr_count
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             load,
  input  logic [TMR_W-1:0] load_val,
  input  logic             flag_clr,
  output logic [TMR_W-1:0] cnt_q,
  output logic             ovf_q,
  output logic             guard
);

  localparam int GW = $clog2(GUARD_CYC + 1);

  logic [GW-1:0] guard_q;
  logic          wrap;

  assign wrap  = step & ~load & (&cnt_q);
  assign guard = (guard_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      guard_q <= '0;
    end else if (load) begin
      cnt_q   <= load_val;
      guard_q <= GW'(GUARD_CYC);
    end else begin
      if (step)  cnt_q   <= bump(cnt_q);
      if (guard) guard_q <= guard_q - GW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ovf_q <= 1'b0;
    else if (wrap)     ovf_q <= 1'b1;
    else if (flag_clr) ovf_q <= 1'b0;
  end

  // R9, R11: a load always wins
  a_r11_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt_q == $past(load_val));
  // R9: counter frozen while the guard window is open
  a_r9_guard_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (guard && !load) |=> $stable(cnt_q));
  // R7, R10: a wrap always leaves the flag set
  a_r10_wrap_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && cnt_q == '1) |=> (ovf_q && cnt_q == '0));
  // R8: flag is sticky without a clearing write
  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !flag_clr) |=> ovf_q);

endmodule

// File: rtl/tick_timer8.sv
module tick_timer8
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inst_tick,
  input  logic       ext_pin,
  input  logic       bus_wr,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       ovf_irq
);

  tmr_ctrl_t        ctl_q;
  logic             pin_rise, pin_fall;
  logic             pin_ev, src_ev, gated_ev, step;
  logic             wr_cnt, wr_ctl, flag_clr;
  logic             guard;
  logic [TMR_W-1:0] cnt_q;
  logic             ovf_q;

  assign wr_cnt   = bus_wr && bus_addr == A_COUNT;
  assign wr_ctl   = bus_wr && bus_addr == A_CTRL;
  assign flag_clr = bus_wr && bus_addr == A_FLAG && !bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (wr_ctl) ctl_q <= tmr_ctrl_t'(bus_wdata[CTRL_W-1:0]);
  end

  tmr_edge_sync #(.STAGES(SYNC_DEPTH)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .pin  (ext_pin),
    .rise (pin_rise),
    .fall (pin_fall)
  );

  assign pin_ev   = ctl_q.edge_fall ? pin_fall : pin_rise;
  assign src_ev   = ctl_q.src_ext ? pin_ev : inst_tick;
  assign gated_ev = src_ev & ~guard & ~wr_cnt;

  tmr_prescale u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .ev_in (gated_ev),
    .clr   (wr_cnt),
    .bypass(ctl_q.bypass),
    .sel   (ctl_q.pre_sel),
    .step  (step)
  );

  tmr_count u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (step),
    .load    (wr_cnt),
    .load_val(bus_wdata[TMR_W-1:0]),
    .flag_clr(flag_clr),
    .cnt_q   (cnt_q),
    .ovf_q   (ovf_q),
    .guard   (guard)
  );

  always_comb begin
    unique case (bus_addr)
      A_COUNT: bus_rdata = 8'(cnt_q);
      A_CTRL:  bus_rdata = 8'(ctl_q);
      A_FLAG:  bus_rdata = {7'd0, ovf_q};
      default: bus_rdata = 8'd0;
    endcase
  end

  assign ovf_irq = ovf_q;

  // R2: internal source ignores the pin
  a_r2_pin_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q.src_ext && !inst_tick) |-> !step);
  // R3: external source ignores the instruction tick
  a_r3_tick_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.src_ext && !pin_rise && !pin_fall) |-> !step);
  // R7: interrupt output follows the flag read at address 2
  a_r7_irq_matches: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_FLAG) |-> (bus_rdata[0] == ovf_irq));

endmodule

// File: tb/tick_timer8_tb.sv
module tick_timer8_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       inst_tick = 1'b0;
  logic       ext_pin = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       ovf_irq;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  tick_timer8 u_dut (
    .clk(clk), .rst_n(rst_n), .inst_tick(inst_tick), .ext_pin(ext_pin),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .ovf_irq(ovf_irq)
  );

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: act=%0d cycles exp=<150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  function automatic int div_of(bit byp, logic [2:0] sel);
    return byp ? 1 : (2 << sel);
  endfunction

  function automatic logic [7:0] ctl_word(bit ext, bit fall, bit byp, logic [2:0] sel);
    return {2'b00, sel, byp, fall, ext};
  endfunction

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic trial(int idx);
    logic [7:0] w   = 8'($urandom);
    bit         ext = 1'($urandom);
    bit         fall = 1'($urandom);
    bit         byp = ($urandom_range(0, 2) == 0);
    logic [2:0] sel = 3'($urandom);
    int         ev  = 0;
    int         total;
    logic [7:0] d;
    repeat (6) @(negedge clk);
    wr(2'd1, ctl_word(ext, fall, byp, sel));
    wr(2'd2, 8'h00);
    wr(2'd0, w);
    repeat (3) @(negedge clk);
    if (ext) begin
      for (int i = 0; i < $urandom_range(2, 60); i++) begin
        ext_pin = ~ext_pin;
        if (ext_pin != fall) ev++;
        for (int k = 0; k < 4; k++) begin
          inst_tick = 1'($urandom);
          @(negedge clk);
        end
      end
      inst_tick = 1'b0;
    end else begin
      for (int i = 0; i < $urandom_range(10, 600); i++) begin
        inst_tick = 1'($urandom);
        ext_pin   = 1'($urandom);
        if (inst_tick) ev++;
        @(negedge clk);
      end
      inst_tick = 1'b0;
    end
    repeat (6) @(negedge clk);
    total = int'(w) + ev / div_of(byp, sel);
    rd(2'd0, d);
    chk(ext ? (fall ? "R3/R4 fall count" : "R3/R4 rise count")
            : (byp ? "R2/R6 tick count" : "R2/R5 divided count"),
        d, total % 256);
    rd(2'd2, d);
    chk("R7 flag after run", d, (total >= 256) ? 1 : 0);
    chk("R7 ovf_irq", ovf_irq, (total >= 256) ? 1 : 0);
    rd(2'd1, d);
    chk("R5 ctrl readback", d, ctl_word(ext, fall, byp, sel));
    if (idx < 0) $display("unused");
  endtask

  initial begin
    logic [7:0] d;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, d); chk("R1 counter reset", d, 0);
    rd(2'd1, d); chk("R1 ctrl reset", d, 0);
    rd(2'd2, d); chk("R1 flag reset", d, 0);
    chk("R1 irq reset", ovf_irq, 0);
    rd(2'd3, d); chk("R1 addr3 reads zero", d, 0);

    // R3 latency: external, rising, bypass
    wr(2'd1, ctl_word(1, 0, 1, 3'd0));
    repeat (4) @(negedge clk);
    wr(2'd0, 8'h10);
    repeat (3) @(negedge clk);
    bus_addr = 2'd0;
    ext_pin = 1'b1;            // set up before edge k
    @(negedge clk);            // after k
    @(negedge clk); #1;        // after k+1
    chk("R3 not yet at k+1", bus_rdata, 8'h10);
    @(negedge clk); #1;        // after k+2
    chk("R3 visible at k+2", bus_rdata, 8'h11);

    // R4 falling select: rise ignored
    wr(2'd1, ctl_word(1, 1, 1, 3'd0));
    repeat (4) @(negedge clk);
    ext_pin = 1'b0; repeat (5) @(negedge clk);
    ext_pin = 1'b1; repeat (5) @(negedge clk);
    rd(2'd0, d); chk("R4 one falling edge counted", d, 8'h12);

    // R5 divide by 8 exactly
    wr(2'd1, ctl_word(0, 0, 0, 3'd2));
    wr(2'd0, 8'h00);
    repeat (3) @(negedge clk);
    for (int i = 0; i < 15; i++) begin inst_tick = 1'b1; @(negedge clk); end
    inst_tick = 1'b0;
    rd(2'd0, d); chk("R5 15 ticks div8", d, 1);
    inst_tick = 1'b1; @(negedge clk); inst_tick = 1'b0;
    rd(2'd0, d); chk("R5 16 ticks div8", d, 2);

    // R9 guard window and prescaler clear
    wr(2'd1, ctl_word(0, 0, 1, 3'd0));
    @(negedge clk); bus_addr = 2'd0; bus_wdata = 8'h40; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0; inst_tick = 1'b1;
    @(negedge clk); @(negedge clk); inst_tick = 1'b0; #1;
    chk("R9 guard drops two events", bus_rdata, 8'h40);
    inst_tick = 1'b1; @(negedge clk); inst_tick = 1'b0; #1;
    chk("R9 counts after guard", bus_rdata, 8'h41);

    // R11 load and event in same cycle
    @(negedge clk); bus_addr = 2'd0; bus_wdata = 8'h77; bus_wr = 1'b1; inst_tick = 1'b1;
    @(negedge clk); bus_wr = 1'b0; inst_tick = 1'b0; #1;
    chk("R11 load wins over event", bus_rdata, 8'h77);

    // R10 wrap and flag clear in same cycle
    wr(2'd0, 8'hFF);
    repeat (3) @(negedge clk);
    bus_addr = 2'd2; bus_wdata = 8'h00; bus_wr = 1'b1; inst_tick = 1'b1;
    @(negedge clk); bus_wr = 1'b0; inst_tick = 1'b0;
    rd(2'd2, d); chk("R10 set beats clear", d, 1);
    rd(2'd0, d); chk("R7 wrap to zero", d, 0);

    // R8 write one keeps flag, write zero clears
    wr(2'd2, 8'h01);
    rd(2'd2, d); chk("R8 write one keeps flag", d, 1);
    wr(2'd2, 8'hFE);
    rd(2'd2, d); chk("R8 write zero clears", d, 0);
    wr(2'd2, 8'h01);
    rd(2'd2, d); chk("R8 write one does not set", d, 0);

    for (int t = 0; t < 40; t++) trial(t);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule